// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address by walking a four-level radix tree of 64-bit entries kept in memory. A translation request carries the virtual address, a write flag and a user flag, and is accepted with a valid/ready handshake. The walker first checks that the address is canonical. It then reads one entry per level through a simple read port. Each read returns one 64-bit word after a variable delay. At every level the walker checks the present and permission bits.

A walk ends on one of three conditions: a leaf entry at the last level, a large-page entry at the second or third level, or a fault. The walker then reports, for one cycle, either the physical address with the leaf's permission flags, or a fault cause with the level at which the fault occurred. Only one memory read is in flight at any time. No new request is taken until the current one has been reported.

Top module: `pt_walker`

## Requirements
- R1: Level 0 is indexed by virtual address bits 47:39, level 1 by bits 38:30, level 2 by bits 29:21 and level 3 by bits 20:12. The levels are read in the order 0, 1, 2, 3. Each read address is the table base plus the 9-bit index times 8.
- R2: An address whose bits 63:48 do not all equal bit 47 is non-canonical. The walker reports it in the cycle after acceptance with cause 1 and level 0, and issues no memory read.
- R3: If entry bit 0 (present) is clear at any level, the walk stops with cause 2 and that level (0 to 3), and no further read is issued.
- R4: A write request that meets an entry with bit 1 (writable) clear, at any level, faults with cause 3 at that level. A read through the same entries succeeds.
- R5: A user request that meets an entry with bit 2 (user) clear, at any level, faults with cause 4 at that level. When an entry fails more than one check, the order of priority is not-present, then write, then user.
- R6: A completed 4 KB walk reports cause 0 and a physical address made of leaf bits 51:12 above virtual bits 11:0. The flags are reported as {bit 63 no-execute, bit 2 user, bit 1 writable} of the leaf.
- R7: Entry bit 7 set at level 1 ends the walk after two reads with a 1 GB mapping: {entry bits 51:30, virtual bits 29:0}. Set at level 2, it ends the walk after three reads with a 2 MB mapping: {entry bits 51:21, virtual bits 20:0}. At levels 0 and 3, bit 7 is ignored.
- R8: At most one memory read is outstanding. The ready output is low from acceptance until the cycle after the one-cycle result pulse, and is high again in that cycle.
- R9: The base of the next table is taken from entry bits 51:12 with the low 12 bits zero. Entry bits 62:52 have no effect on the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 64 | Virtual address to translate |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | Request comes from user mode |
| root_frame | input | 40 | Frame number of the level-0 table, sampled on acceptance |
| mem_req_valid | output | 1 | One-cycle read strobe |
| mem_req_addr | output | 52 | Byte address of the entry being read |
| mem_resp_valid | input | 1 | Read data present |
| mem_resp_data | input | 64 | Entry returned by memory |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_paddr | output | 52 | Translated physical address, zero on a fault |
| rsp_flags | output | 3 | Leaf {no-execute, user, writable}, zero on a fault |
| rsp_fault | output | 3 | 0 none, 1 non-canonical, 2 not present, 3 write-protect, 4 privilege |
| rsp_level | output | 2 | Level of the fault or of the leaf |

## Verification
The bench targets the following corner cases:
- Both halves of the canonical space, plus addresses where only bit 63 or only bit 47 breaks the rule. A weak canonical check would start a walk and issue reads.
- Missing entries at the first and at the last level. A walker that checks only the leaf, or that reports the wrong level, would give a wrong cause or level, or the wrong read count.
- Permission faults raised by an intermediate entry, and an entry that fails both the write and the user check. Wrong check order, or checks on the leaf alone, would show here.
- 1 GB and 2 MB leaves, and bit 7 set at levels 0 and 3 where it must be ignored. A walker with wrong pass-through widths would corrupt the address, and one that decodes bit 7 at every level would stop early.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int ENTRY_W   = 64;
    localparam int BIT_PRES  = 0;
    localparam int BIT_WR    = 1;
    localparam int BIT_USR   = 2;
    localparam int BIT_LARGE = 7;
    localparam int BIT_NX    = 63;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_NONCANON = 3'd1,
        FLT_ABSENT   = 3'd2,
        FLT_WRPROT   = 3'd3,
        FLT_PRIV     = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } walk_state_e;

endpackage

// File: rtl/ptw_va_decode.sv
module ptw_va_decode #(
    parameter int VA_W   = 48,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 4,
    parameter int LVL_W  = 2
) (
    input  logic [63:0]       check_va,
    input  logic [63:0]       walk_va,
    input  logic [LVL_W-1:0]  level,
    output logic              canonical,
    output logic [IDX_W-1:0]  index
);
    localparam int TOP_BIT = OFF_W + LEVELS * IDX_W;

    logic [IDX_W-1:0] idx_arr [LEVELS];

    // level 0 takes the highest slice of the walked address
    for (genvar l = 0; l < LEVELS; l++) begin : g_slice
        assign idx_arr[l] = walk_va[OFF_W + (LEVELS-1-l)*IDX_W +: IDX_W];
    end

    assign index = idx_arr[level];

    logic [63-VA_W+1:0] sign_ext;
    assign sign_ext  = check_va[63:VA_W-1];
    assign canonical = (&sign_ext) || (~|sign_ext);

    logic unused_va;
    assign unused_va = ^{check_va[VA_W-2:0], walk_va[63:TOP_BIT], walk_va[OFF_W-1:0]};

endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
    import ptw_pkg::*;
#(
    parameter int PA_W   = 52,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 4,
    parameter int LVL_W  = 2,
    parameter logic [LEVELS-1:0] LARGE_MASK = 4'b0110
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [LVL_W-1:0]   level,
    input  logic               is_write,
    input  logic               is_user,
    input  logic [63:0]        vaddr,
    output fault_e             fault,
    output logic               leaf,
    output logic [PA_W-OFF_W-1:0] next_frame,
    output logic [PA_W-1:0]    paddr
);
    localparam int SH_ROOT = OFF_W + (LEVELS-1)*IDX_W;

    logic [PA_W-1:0] pa_arr [LEVELS];

    // a leaf at level l passes through every address bit below its index
    for (genvar l = 0; l < LEVELS; l++) begin : g_leaf_pa
        localparam int SH = OFF_W + (LEVELS-1-l)*IDX_W;
        assign pa_arr[l] = {entry[PA_W-1:SH], vaddr[SH-1:0]};
    end

    always_comb begin
        if (!entry[BIT_PRES]) begin
            fault = FLT_ABSENT;
        end else if (is_write && !entry[BIT_WR]) begin
            fault = FLT_WRPROT;
        end else if (is_user && !entry[BIT_USR]) begin
            fault = FLT_PRIV;
        end else begin
            fault = FLT_NONE;
        end
    end

    assign leaf       = (level == LVL_W'(LEVELS-1)) || (entry[BIT_LARGE] && LARGE_MASK[level]);
    assign next_frame = entry[PA_W-1:OFF_W];
    assign paddr      = pa_arr[level];

    logic unused_bits;
    assign unused_bits = ^{entry[ENTRY_W-1:PA_W], entry[OFF_W-1:BIT_LARGE+1],
                           entry[BIT_LARGE-1:BIT_USR+1], vaddr[63:SH_ROOT]};

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int PA_W   = 52,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 4,
    parameter int LVL_W  = $clog2(LEVELS),
    parameter int FRAME_W = PA_W - OFF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [63:0]         req_vaddr,
    input  logic                req_write,
    input  logic                req_user,
    input  logic [FRAME_W-1:0]  root_frame,
    output logic                mem_req_valid,
    output logic [PA_W-1:0]     mem_req_addr,
    input  logic                mem_resp_valid,
    input  logic [ENTRY_W-1:0]  mem_resp_data,
    output logic                rsp_valid,
    output logic [PA_W-1:0]     rsp_paddr,
    output logic [2:0]          rsp_flags,
    output logic [2:0]          rsp_fault,
    output logic [LVL_W-1:0]    rsp_level
);
    localparam int ENTRY_BYTES_LOG = OFF_W - IDX_W;

    typedef struct packed {
        walk_state_e        st;
        logic [63:0]        va;
        logic               wr;
        logic               usr;
        logic [FRAME_W-1:0] base;
        logic [LVL_W-1:0]   lvl;
        logic [PA_W-1:0]    pa;
        logic [2:0]         flags;
        fault_e             flt;
    } walk_s;

    walk_s q, d;

    logic             va_canon;
    logic [IDX_W-1:0] va_index;
    fault_e           ev_fault;
    logic             ev_leaf;
    logic [FRAME_W-1:0] ev_next;
    logic [PA_W-1:0]  ev_paddr;

    ptw_va_decode #(
        .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W)
    ) i_decode (
        .check_va  (req_vaddr),
        .walk_va   (q.va),
        .level     (q.lvl),
        .canonical (va_canon),
        .index     (va_index)
    );

    ptw_entry_eval #(
        .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W)
    ) i_eval (
        .entry      (mem_resp_data),
        .level      (q.lvl),
        .is_write   (q.wr),
        .is_user    (q.usr),
        .vaddr      (q.va),
        .fault      (ev_fault),
        .leaf       (ev_leaf),
        .next_frame (ev_next),
        .paddr      (ev_paddr)
    );

    always_comb begin
        d             = q;
        mem_req_valid = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.va    = req_vaddr;
                    d.wr    = req_write;
                    d.usr   = req_user;
                    d.base  = root_frame;
                    d.lvl   = '0;
                    d.pa    = '0;
                    d.flags = '0;
                    if (!va_canon) begin
                        d.flt = FLT_NONCANON;
                        d.st  = ST_DONE;
                    end else begin
                        d.flt = FLT_NONE;
                        d.st  = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                mem_req_valid = 1'b1;
                d.st          = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_resp_valid) begin
                    if (ev_fault != FLT_NONE) begin
                        d.flt = ev_fault;
                        d.st  = ST_DONE;
                    end else if (ev_leaf) begin
                        d.pa    = ev_paddr;
                        d.flags = {mem_resp_data[BIT_NX], mem_resp_data[BIT_USR], mem_resp_data[BIT_WR]};
                        d.st    = ST_DONE;
                    end else begin
                        d.base = ev_next;
                        d.lvl  = q.lvl + 1'b1;
                        d.st   = ST_ISSUE;
                    end
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready    = (q.st == ST_IDLE);
    assign mem_req_addr = {q.base, va_index, {ENTRY_BYTES_LOG{1'b0}}};
    assign rsp_valid    = (q.st == ST_DONE);
    assign rsp_paddr    = q.pa;
    assign rsp_flags    = q.flags;
    assign rsp_fault    = q.flt;
    assign rsp_level    = q.lvl;

    // ---------------- assertions ----------------
    logic outst_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= 1'b0;
        end else if (mem_req_valid) begin
            outst_q <= 1'b1;
        end else if (mem_resp_valid) begin
            outst_q <= 1'b0;
        end
    end

    p_one_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !outst_q);

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_result_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    p_noncanon_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready &&
         !((&req_vaddr[63:VA_W-1]) || (~|req_vaddr[63:VA_W-1])))
        |=> (rsp_valid && rsp_fault == FLT_NONCANON && rsp_level == '0 && !mem_req_valid));

    p_fault_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0 && rsp_flags == '0));

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [39:0] root_frame = 40'd1;
    logic        mem_req_valid;
    logic [51:0] mem_req_addr;
    logic        mem_resp_valid = 1'b0;
    logic [63:0] mem_resp_data = '0;
    logic        rsp_valid;
    logic [51:0] rsp_paddr;
    logic [2:0]  rsp_flags;
    logic [2:0]  rsp_fault;
    logic [1:0]  rsp_level;

    always #5 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .root_frame(root_frame),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_flags(rsp_flags),
        .rsp_fault(rsp_fault), .rsp_level(rsp_level)
    );

    int checks = 0;
    int bad = 0;
    bit done = 0;

    // ---------------- memory model ----------------
    logic [63:0] mem [0:4095];
    int          lat = 0;
    int          nreads = 0;
    logic [51:0] rd_log [0:15];
    logic        pend = 1'b0;
    int          cnt = 0;
    logic [51:0] pa_pend = '0;
    bit          overlap_bad = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_resp_valid <= 1'b0;
            pend <= 1'b0;
        end else begin
            mem_resp_valid <= 1'b0;
            if (mem_req_valid) begin
                if (pend) overlap_bad <= 1;
                pend    <= 1'b1;
                cnt     <= lat;
                pa_pend <= mem_req_addr;
                rd_log[nreads % 16] <= mem_req_addr;
                nreads  <= nreads + 1;
            end else if (pend) begin
                if (cnt == 0) begin
                    mem_resp_valid <= 1'b1;
                    mem_resp_data  <= (pa_pend[51:15] == '0) ? mem[{pa_pend[14:12], pa_pend[11:3]}] : 64'd0;
                    pend <= 1'b0;
                end else begin
                    cnt <= cnt - 1;
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input [63:0] act, input [63:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input [63:0] act, input [63:0] exp);
        chk(act == exp, req, act, exp);
    endtask

    function automatic [8:0] ix(input [63:0] va, input int l);
        return va[39-9*l +: 9];
    endfunction

    function automatic [63:0] mk(input [39:0] fr, input bit p, input bit w, input bit u,
                                 input bit big, input bit nx);
        logic [63:0] e;
        e = '0;
        e[51:12] = fr;
        e[0] = p; e[1] = w; e[2] = u; e[7] = big; e[63] = nx;
        return e;
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = '0;
    endtask

    // standard chain: root frame 1 -> 2 -> 3 -> 4, all entries present/writable/user
    task automatic build_chain(input [63:0] va, input [63:0] leaf);
        mem[{3'd1, ix(va, 0)}] = mk(40'd2, 1, 1, 1, 0, 0);
        mem[{3'd2, ix(va, 1)}] = mk(40'd3, 1, 1, 1, 0, 0);
        mem[{3'd3, ix(va, 2)}] = mk(40'd4, 1, 1, 1, 0, 0);
        mem[{3'd4, ix(va, 3)}] = leaf;
    endtask

    logic [51:0] got_pa;
    logic [2:0]  got_flags, got_fault;
    logic [1:0]  got_level;
    int          got_reads, got_cyc, rd_base;
    bit          busy_bad, ready_back;

    task automatic do_walk(input [63:0] va, input bit wr, input bit usr);
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
        rd_base = nreads;
        busy_bad = 0;
        if (!req_ready) busy_bad = 1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        got_cyc = 1;
        while (!rsp_valid && got_cyc < 300) begin
            if (req_ready) busy_bad = 1;
            @(negedge clk);
            got_cyc++;
        end
        got_pa = rsp_paddr; got_flags = rsp_flags;
        got_fault = rsp_fault; got_level = rsp_level;
        @(negedge clk);
        ready_back = req_ready && !rsp_valid;
        got_reads = nreads - rd_base;
    endtask

    task automatic chk_handshake(input string tag);
        chk(!busy_bad, {tag, " ready low while busy"}, 64'(busy_bad), 0);
        chk(ready_back, {tag, " ready back after pulse"}, 64'(ready_back), 1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk_eq("R8 reset ready", 64'(req_ready), 1);
        chk_eq("R8 reset rsp_valid", 64'(rsp_valid), 0);
        chk_eq("R8 reset mem_req_valid", 64'(mem_req_valid), 0);
    endtask

    task automatic t_walk_4k();
        logic [63:0] va;
        va = 64'h0000_1234_5678_9ABC;
        clear_mem();
        build_chain(va, mk(40'h12345, 1, 1, 1, 0, 1));
        mem[{3'd2, ix(va, 1)}][62:52] = 11'h5A5; // R9 junk bits
        lat = 2;
        do_walk(va, 1, 1);
        chk_eq("R6 fault none", 64'(got_fault), 0);
        chk_eq("R6 paddr 4k", 64'(got_pa), 64'({40'h12345, va[11:0]}));
        chk_eq("R6 flags", 64'(got_flags), 3'b111);
        chk_eq("R6 level", 64'(got_level), 3);
        chk_eq("R1 read count", 64'(got_reads), 4);
        chk_eq("R1 addr level0", 64'(rd_log[(rd_base+0)%16]), 64'({40'd1, ix(va,0), 3'b000}));
        chk_eq("R1 addr level1", 64'(rd_log[(rd_base+1)%16]), 64'({40'd2, ix(va,1), 3'b000}));
        chk_eq("R9 addr level2 ignores high bits", 64'(rd_log[(rd_base+2)%16]), 64'({40'd3, ix(va,2), 3'b000}));
        chk_eq("R1 addr level3", 64'(rd_log[(rd_base+3)%16]), 64'({40'd4, ix(va,3), 3'b000}));
        chk_handshake("R8 4k");
    endtask

    task automatic t_upper_half();
        logic [63:0] va;
        va = 64'hFFFF_8765_4321_0FED;
        clear_mem();
        build_chain(va, mk(40'hABCDE, 1, 0, 0, 0, 0));
        lat = 5;
        do_walk(va, 0, 0);
        chk_eq("R2 upper half canonical fault", 64'(got_fault), 0);
        chk_eq("R6 upper half paddr", 64'(got_pa), 64'({40'hABCDE, va[11:0]}));
        chk_eq("R6 upper half flags", 64'(got_flags), 0);
        chk_eq("R1 upper half reads", 64'(got_reads), 4);
        chk_eq("R1 upper half root index", 64'(rd_log[rd_base%16]), 64'({40'd1, 9'h10E, 3'b000}));
    endtask

    task automatic t_noncanon(input [63:0] va, input string tag);
        lat = 1;
        do_walk(va, 0, 0);
        chk_eq({"R2 cause ", tag}, 64'(got_fault), 1);
        chk_eq({"R2 level ", tag}, 64'(got_level), 0);
        chk_eq({"R2 no reads ", tag}, 64'(got_reads), 0);
        chk_eq({"R2 one cycle ", tag}, 64'(got_cyc), 1);
        chk_eq({"R2 paddr zero ", tag}, 64'(got_pa), 0);
    endtask

    task automatic t_absent();
        logic [63:0] va;
        va = 64'h0000_7000_0020_3456;
        clear_mem();
        lat = 0;
        do_walk(va, 0, 0);
        chk_eq("R3 root absent cause", 64'(got_fault), 2);
        chk_eq("R3 root absent level", 64'(got_level), 0);
        chk_eq("R3 root absent reads", 64'(got_reads), 1);
        build_chain(va, mk(40'h777, 0, 1, 1, 0, 0));
        lat = 3;
        do_walk(va, 1, 1);
        chk_eq("R3 leaf absent cause beats write/user", 64'(got_fault), 2);
        chk_eq("R3 leaf absent level", 64'(got_level), 3);
        chk_eq("R3 leaf absent reads", 64'(got_reads), 4);
        chk_handshake("R8 absent");
    endtask

    task automatic t_write_prot();
        logic [63:0] va;
        va = 64'h0000_0040_1000_0123;
        clear_mem();
        build_chain(va, mk(40'h55, 1, 1, 1, 0, 0));
        mem[{3'd3, ix(va, 2)}] = mk(40'd4, 1, 0, 1, 0, 0);
        lat = 1;
        do_walk(va, 1, 0);
        chk_eq("R4 write cause", 64'(got_fault), 3);
        chk_eq("R4 write level", 64'(got_level), 2);
        chk_eq("R4 write reads", 64'(got_reads), 3);
        do_walk(va, 0, 0);
        chk_eq("R4 read same page ok", 64'(got_fault), 0);
        chk_eq("R4 read same page paddr", 64'(got_pa), 64'({40'h55, va[11:0]}));
    endtask

    task automatic t_user();
        logic [63:0] va;
        va = 64'h0000_0022_3344_5AA5;
        clear_mem();
        build_chain(va, mk(40'h99, 1, 1, 0, 0, 0));
        lat = 0;
        do_walk(va, 0, 1);
        chk_eq("R5 user cause", 64'(got_fault), 4);
        chk_eq("R5 user level", 64'(got_level), 3);
        do_walk(va, 0, 0);
        chk_eq("R5 supervisor ok", 64'(got_fault), 0);
        chk_eq("R5 supervisor flags", 64'(got_flags), 3'b001);
        mem[{3'd2, ix(va, 1)}] = mk(40'd3, 1, 0, 0, 0, 0);
        do_walk(va, 1, 1);
        chk_eq("R5 write beats user cause", 64'(got_fault), 3);
        chk_eq("R5 write beats user level", 64'(got_level), 1);
    endtask

    task automatic t_large();
        logic [63:0] va;
        logic [39:0] fr;
        va = 64'h0000_5A5A_3C3C_1234;
        fr = 40'h00005_C0000;
        clear_mem();
        build_chain(va, mk(40'h1, 1, 1, 1, 0, 0));
        mem[{3'd2, ix(va, 1)}] = mk(fr, 1, 1, 1, 1, 0);
        lat = 2;
        do_walk(va, 0, 0);
        chk_eq("R7 1G fault", 64'(got_fault), 0);
        chk_eq("R7 1G paddr", 64'(got_pa), 64'({fr[39:18], va[29:0]}));
        chk_eq("R7 1G reads", 64'(got_reads), 2);
        chk_eq("R7 1G level", 64'(got_level), 1);
        fr = 40'h00ABC_DE000;
        mem[{3'd2, ix(va, 1)}] = mk(40'd3, 1, 1, 1, 0, 0);
        mem[{3'd3, ix(va, 2)}] = mk(fr, 1, 0, 1, 1, 1);
        do_walk(va, 0, 1);
        chk_eq("R7 2M paddr", 64'(got_pa), 64'({fr[39:9], va[20:0]}));
        chk_eq("R7 2M reads", 64'(got_reads), 3);
        chk_eq("R7 2M flags", 64'(got_flags), 3'b110);
        mem[{3'd3, ix(va, 2)}] = mk(40'd4, 1, 1, 1, 0, 0);
        mem[{3'd1, ix(va, 0)}] = mk(40'd2, 1, 1, 1, 1, 0);
        mem[{3'd4, ix(va, 3)}] = mk(40'h4242, 1, 1, 1, 1, 0);
        do_walk(va, 0, 0);
        chk_eq("R7 bit7 ignored at levels 0/3 reads", 64'(got_reads), 4);
        chk_eq("R7 bit7 ignored at levels 0/3 paddr", 64'(got_pa), 64'({40'h4242, va[11:0]}));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        int wd;
        wd = 0;
        while (wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        checks++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=done", wd);
        finish_run();
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_walk_4k();
        t_upper_half();
        t_noncanon(64'h8000_1234_5678_9ABC, "bit63");
        t_noncanon(64'h0000_8000_0000_1000, "bit47");
        t_absent();
        t_write_prot();
        t_user();
        t_large();
        chk(!overlap_bad, "R8 single outstanding read", 64'(overlap_bad), 0);
        finish_run();
    end

endmodule